// File: doc/BRIEF.md
# Operand Effective Address Generator

This block sits beside an instruction decoder and works out where an instruction's operand lives. When the decoder has read an opcode, it pulses `start` together with the addressing mode, the index register choice, the immediate width, the byte order in use and the PC of the first operand byte. The block then takes as many operand bytes from the instruction stream as the mode needs, through a valid/data pair. It reports the 16-bit effective address, along with the number of operand bytes by which the PC must advance, in a one-cycle `done` pulse.

Four modes are supported. Page-zero mode uses one byte as the low half of the address and a high half of zero. Full-address mode joins two bytes, and `msb_first` chooses which of them is the high half. Indexed mode adds an unsigned byte offset to a copy of X or Y and leaves the registers themselves untouched. Immediate mode needs no bytes at all, because its address is the PC of the data. Every operation input is captured when `start` is taken, so the decoder may change those inputs while operand bytes are still arriving.

Top module: `opaddr_unit`

## Requirements
- R1: Right after reset, `done` and `busy` are 0 and `ea` and `pc_step` are 0.
- R2: Mode 2'b00 (page zero) takes one byte B and gives `ea` = {8'h00, B} and `pc_step` = 1. `done` is high in the cycle after the edge that takes B.
- R3: Mode 2'b01 (full address) with `msb_first` = 0 takes the low address byte first and the high byte second. For example, 37 then 42 gives `ea` = 16'h4237. `pc_step` = 2.
- R4: Mode 2'b01 with `msb_first` = 1 takes the high address byte first. For example, 42 then 37 gives `ea` = 16'h4237. `pc_step` = 2.
- R5: Mode 2'b10 (indexed) takes one offset byte. It gives `ea` = base + zero-extended offset, modulo 2^16, where base is `idx_x` when `idx_sel` = 0 and `idx_y` when `idx_sel` = 1. `pc_step` = 1.
- R6: Mode 2'b11 (immediate) takes no bytes. It gives `ea` = `pc_in` and `done` in the cycle after `start` is taken. `pc_step` is 2 when `wide_imm` = 1 and 1 otherwise.
- R7: `done` is high for exactly one cycle per operation. `ea` and `pc_step` hold their values until the next `done`.
- R8: A `start` while `busy` is high is ignored, and `byte_valid` while idle is ignored. Neither produces `done` or changes the result.
- R9: Mode, index choice, base value, PC, width and byte order are sampled when `start` is taken. Later changes to those inputs do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an address computation; taken only when idle |
| mode | input | 2 | 00 page zero, 01 full address, 10 indexed, 11 immediate |
| idx_sel | input | 1 | 0 selects `idx_x`, 1 selects `idx_y` as base |
| wide_imm | input | 1 | Immediate operand is two bytes |
| msb_first | input | 1 | Full-address byte order: 1 high byte first, 0 low byte first |
| pc_in | input | 16 | PC of the first operand byte |
| idx_x | input | 16 | Index register X value |
| idx_y | input | 16 | Index register Y value |
| byte_valid | input | 1 | `byte_in` carries an operand byte this cycle |
| byte_in | input | 8 | Operand byte from the instruction stream |
| ea | output | 16 | Effective address, held between results |
| pc_step | output | 2 | Operand bytes consumed, held between results |
| done | output | 1 | One-cycle pulse when `ea` and `pc_step` are new |
| busy | output | 1 | Waiting for operand bytes |

## Verification
Page-zero bytes 37 and FF show whether the high half is forced to zero across the whole byte range. The same address is sent in both byte orders, once with an idle gap between the bytes, which separates a swapped join from a correct one and checks that a stalled stream is tolerated. Indexed cases use X with a small offset, Y near the top of the space, and offset FF. These catch sign extension, the wrong register and a missing wrap. Immediate cases at both widths, stray starts and bytes, and input changes during the wait check the step count, the ignore rules and the capture at `start`.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

  typedef enum logic [1:0] {
    MODE_PAGE0 = 2'b00,
    MODE_FULL  = 2'b01,
    MODE_INDEX = 2'b10,
    MODE_IMM   = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_LO   = 2'b01,
    ST_HI   = 2'b10
  } fetch_state_e;

endpackage

// File: rtl/opaddr_seq.sv
module opaddr_seq
  import opaddr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  addr_mode_e mode_in,
  input  addr_mode_e mode_q,
  input  logic       byte_valid,
  output logic       take_start,
  output logic       imm_fire,
  output logic       take_byte,
  output logic       last_byte,
  output logic       busy
);

  fetch_state_e state_q, state_d;

  assign busy       = (state_q != ST_IDLE);
  assign take_start = start && !busy;
  assign imm_fire   = take_start && (mode_in == MODE_IMM);
  assign take_byte  = byte_valid && busy;
  assign last_byte  = take_byte && ((state_q == ST_HI) || (mode_q != MODE_FULL));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (take_start && !imm_fire) state_d = ST_LO;
      ST_LO:   if (take_byte) state_d = last_byte ? ST_IDLE : ST_HI;
      ST_HI:   if (take_byte) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/opaddr_capture.sv
module opaddr_capture
  import opaddr_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_start,
  input  logic          take_byte,
  input  logic          last_byte,
  input  addr_mode_e    mode_in,
  input  logic          idx_sel,
  input  logic          wide_imm,
  input  logic          msb_first,
  input  logic [AW-1:0] idx_x,
  input  logic [AW-1:0] idx_y,
  input  logic [BW-1:0] byte_in,
  output addr_mode_e    mode_q,
  output logic          wide_q,
  output logic          msbf_q,
  output logic [AW-1:0] base_q,
  output logic [BW-1:0] first_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_PAGE0;
      wide_q  <= 1'b0;
      msbf_q  <= 1'b0;
      base_q  <= '0;
      first_q <= '0;
    end else begin
      if (take_start) begin
        mode_q <= mode_in;
        wide_q <= wide_imm;
        msbf_q <= msb_first;
        base_q <= idx_sel ? idx_y : idx_x;
      end
      if (take_byte && !last_byte) first_q <= byte_in;
    end
  end

endmodule

// File: rtl/opaddr_calc.sv
module opaddr_calc
  import opaddr_pkg::*;
#(
  parameter int AW    = 16,
  parameter int BW    = 8,
  parameter int STEPW = 2
) (
  input  addr_mode_e       mode_q,
  input  logic             msbf_q,
  input  logic [AW-1:0]    base_q,
  input  logic [BW-1:0]    first_q,
  input  logic [BW-1:0]    byte_in,
  output logic [AW-1:0]    ea_calc,
  output logic [STEPW-1:0] step_calc
);

  localparam int PADW = AW - BW;

  function automatic logic [AW-1:0] page0_addr(input logic [BW-1:0] b);
    return {{PADW{1'b0}}, b};
  endfunction

  function automatic logic [AW-1:0] join_addr(input logic [BW-1:0] b0,
                                              input logic [BW-1:0] b1,
                                              input logic hi_first);
    return hi_first ? {b0, b1} : {b1, b0};
  endfunction

  function automatic logic [AW-1:0] offset_addr(input logic [AW-1:0] base,
                                                input logic [BW-1:0] off);
    logic [AW:0] sum;
    sum = {1'b0, base} + {{(PADW + 1){1'b0}}, off};
    return sum[AW-1:0];
  endfunction

  function automatic logic [STEPW-1:0] byte_count(input addr_mode_e m);
    return (m == MODE_FULL) ? STEPW'(2) : STEPW'(1);
  endfunction

  always_comb begin
    unique case (mode_q)
      MODE_PAGE0: ea_calc = page0_addr(byte_in);
      MODE_FULL:  ea_calc = join_addr(first_q, byte_in, msbf_q);
      MODE_INDEX: ea_calc = offset_addr(base_q, byte_in);
      default:    ea_calc = '0;
    endcase
    step_calc = byte_count(mode_q);
  end

endmodule

// File: rtl/opaddr_unit.sv
module opaddr_unit
  import opaddr_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic          idx_sel,
  input  logic          wide_imm,
  input  logic          msb_first,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] idx_x,
  input  logic [AW-1:0] idx_y,
  input  logic          byte_valid,
  input  logic [BW-1:0] byte_in,
  output logic [AW-1:0] ea,
  output logic [1:0]    pc_step,
  output logic          done,
  output logic          busy
);

  localparam int STEPW = 2;

  addr_mode_e       mode_in, mode_q;
  logic             take_start, imm_fire, take_byte, last_byte;
  logic             wide_q, msbf_q;
  logic [AW-1:0]    base_q, ea_calc;
  logic [BW-1:0]    first_q;
  logic [STEPW-1:0] step_calc;

  assign mode_in = addr_mode_e'(mode);

  opaddr_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode_in),
    .mode_q(mode_q), .byte_valid(byte_valid), .take_start(take_start),
    .imm_fire(imm_fire), .take_byte(take_byte), .last_byte(last_byte),
    .busy(busy)
  );

  opaddr_capture #(.AW(AW), .BW(BW)) u_cap (
    .clk(clk), .rst_n(rst_n), .take_start(take_start), .take_byte(take_byte),
    .last_byte(last_byte), .mode_in(mode_in), .idx_sel(idx_sel),
    .wide_imm(wide_imm), .msb_first(msb_first), .idx_x(idx_x), .idx_y(idx_y),
    .byte_in(byte_in), .mode_q(mode_q), .wide_q(wide_q), .msbf_q(msbf_q),
    .base_q(base_q), .first_q(first_q)
  );

  opaddr_calc #(.AW(AW), .BW(BW), .STEPW(STEPW)) u_calc (
    .mode_q(mode_q), .msbf_q(msbf_q), .base_q(base_q), .first_q(first_q),
    .byte_in(byte_in), .ea_calc(ea_calc), .step_calc(step_calc)
  );

  // Result register: immediate finishes at start, others on their last byte.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea      <= '0;
      pc_step <= '0;
      done    <= 1'b0;
    end else if (imm_fire) begin
      ea      <= pc_in;
      pc_step <= wide_imm ? STEPW'(2) : STEPW'(1);
      done    <= 1'b1;
    end else if (last_byte) begin
      ea      <= ea_calc;
      pc_step <= step_calc;
      done    <= 1'b1;
    end else begin
      done    <= 1'b0;
    end
  end

  // wide_q is kept for the checker: it records the width of the last immediate.
  logic imm_wide_seen;
  assign imm_wide_seen = wide_q;

endmodule

// File: rtl/opaddr_unit_chk.sv
module opaddr_unit_chk
  import opaddr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        done,
  input logic        busy,
  input logic [15:0] ea,
  input logic [1:0]  pc_step,
  input addr_mode_e  mode_q,
  input logic        imm_fire,
  input logic        last_byte,
  input logic        imm_wide_seen
);

  AST_PAGE0_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == MODE_PAGE0) |-> (ea[15:8] == 8'h00)); // R2

  AST_FULL_STEP_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == MODE_FULL) |-> (pc_step == 2'd2)); // R3

  AST_IMM_STEP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == MODE_IMM) |-> (pc_step == (imm_wide_seen ? 2'd2 : 2'd1))); // R6

  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(imm_fire || last_byte)); // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(ea) && $stable(pc_step))); // R7

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mode_q)); // R8

endmodule

bind opaddr_unit opaddr_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .busy(busy),
  .ea(ea), .pc_step(pc_step), .mode_q(mode_q), .imm_fire(imm_fire),
  .last_byte(last_byte), .imm_wide_seen(imm_wide_seen)
);

// File: tb/opaddr_unit_tb.sv
module opaddr_unit_tb;

  localparam logic [1:0] M_PAGE0 = 2'b00;
  localparam logic [1:0] M_FULL  = 2'b01;
  localparam logic [1:0] M_INDEX = 2'b10;
  localparam logic [1:0] M_IMM   = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        idx_sel = 1'b0;
  logic        wide_imm = 1'b0;
  logic        msb_first = 1'b0;
  logic [15:0] pc_in = '0;
  logic [15:0] idx_x = '0;
  logic [15:0] idx_y = '0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_in = '0;
  logic [15:0] ea;
  logic [1:0]  pc_step;
  logic        done;
  logic        busy;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  opaddr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .idx_sel(idx_sel),
    .wide_imm(wide_imm), .msb_first(msb_first), .pc_in(pc_in), .idx_x(idx_x),
    .idx_y(idx_y), .byte_valid(byte_valid), .byte_in(byte_in), .ea(ea),
    .pc_step(pc_step), .done(done), .busy(busy)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Issue one operation and check its result and the following hold cycle.
  task automatic run_op(input string req, input logic [1:0] m, input logic sel,
                        input logic wide, input logic hi_first,
                        input logic [15:0] pc, input int nbytes,
                        input logic [7:0] b0, input logic [7:0] b1,
                        input bit gap, input bit disturb,
                        input logic [15:0] exp_ea, input logic [1:0] exp_step);
    @(negedge clk);
    start = 1'b1; mode = m; idx_sel = sel; wide_imm = wide;
    msb_first = hi_first; pc_in = pc;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      mode = ~m; idx_sel = ~sel; wide_imm = ~wide; msb_first = ~hi_first;
      pc_in = ~pc; idx_x = idx_x ^ 16'h5A5A; idx_y = idx_y ^ 16'hA5A5;
    end
    for (int i = 0; i < nbytes; i++) begin
      if (gap && i == 1) @(negedge clk);
      byte_valid = 1'b1;
      byte_in = (i == 0) ? b0 : b1;
      @(negedge clk);
      byte_valid = 1'b0;
    end
    check(req, "done pulse", done, 1);
    check(req, "ea", ea, exp_ea);
    check(req, "pc_step", pc_step, exp_step);
    @(negedge clk);
    check("R7", "done low after pulse", done, 0);
    check("R7", "ea held", ea, exp_ea);
  endtask

  task automatic t_reset;
    check("R1", "done", done, 0);
    check("R1", "busy", busy, 0);
    check("R1", "ea", ea, 0);
    check("R1", "pc_step", pc_step, 0);
  endtask

  task automatic t_page0;
    run_op("R2", M_PAGE0, 0, 0, 0, 16'h1000, 1, 8'h37, 8'h00, 0, 0, 16'h0037, 2'd1);
    run_op("R2", M_PAGE0, 0, 0, 1, 16'h1000, 1, 8'hFF, 8'h00, 0, 0, 16'h00FF, 2'd1);
  endtask

  task automatic t_full;
    run_op("R3", M_FULL, 0, 0, 0, 16'h5021, 2, 8'h37, 8'h42, 0, 0, 16'h4237, 2'd2);
    run_op("R3", M_FULL, 0, 0, 0, 16'h5021, 2, 8'h34, 8'hAB, 1, 0, 16'hAB34, 2'd2);
    run_op("R4", M_FULL, 0, 0, 1, 16'h3AB1, 2, 8'h42, 8'h37, 0, 0, 16'h4237, 2'd2);
  endtask

  task automatic t_index;
    idx_x = 16'h1234; idx_y = 16'hFFF0;
    run_op("R5", M_INDEX, 0, 0, 0, 16'h0, 1, 8'h2A, 8'h00, 0, 0, 16'h125E, 2'd1);
    run_op("R5", M_INDEX, 1, 0, 0, 16'h0, 1, 8'h20, 8'h00, 0, 0, 16'h0010, 2'd1);
    run_op("R5", M_INDEX, 0, 0, 0, 16'h0, 1, 8'hFF, 8'h00, 0, 0, 16'h1333, 2'd1);
    check("R5", "X unchanged", idx_x, 16'h1234);
  endtask

  task automatic t_imm;
    run_op("R6", M_IMM, 0, 0, 0, 16'h0101, 0, 8'h00, 8'h00, 0, 0, 16'h0101, 2'd1);
    run_op("R6", M_IMM, 0, 1, 0, 16'hA32C, 0, 8'h00, 8'h00, 0, 0, 16'hA32C, 2'd2);
  endtask

  task automatic t_ignore;
    // R8: stray bytes while idle
    @(negedge clk);
    byte_valid = 1'b1; byte_in = 8'h99;
    @(negedge clk);
    byte_valid = 1'b0;
    check("R8", "no done from idle byte", done, 0);
    check("R8", "still idle", busy, 0);
    check("R8", "ea unchanged by idle byte", ea, 16'hA32C);
    // R8: immediate start while waiting for a page-zero byte
    @(negedge clk);
    start = 1'b1; mode = M_PAGE0; pc_in = 16'h2000;
    @(negedge clk);
    check("R8", "busy after start", busy, 1);
    mode = M_IMM; pc_in = 16'h7777;
    @(negedge clk);
    start = 1'b0;
    check("R8", "no done from busy start", done, 0);
    byte_valid = 1'b1; byte_in = 8'h5C;
    @(negedge clk);
    byte_valid = 1'b0;
    check("R8", "done after byte", done, 1);
    check("R8", "ea from first start", ea, 16'h005C);
    @(negedge clk);
    check("R8", "no late done", done, 0);
  endtask

  task automatic t_capture;
    idx_x = 16'h1000; idx_y = 16'h0000;
    run_op("R9", M_INDEX, 0, 0, 0, 16'h0, 1, 8'h10, 8'h00, 0, 1, 16'h1010, 2'd1);
    run_op("R9", M_FULL, 0, 0, 1, 16'h0, 2, 8'hC0, 8'h07, 1, 1, 16'hC007, 2'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_page0();
    t_full();
    t_index();
    t_imm();
    t_ignore();
    t_capture();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule